// File: doc/BRIEF.md
# Context Model Set Cache

This block is a small, fully associative store of probability-state groups placed between the context selection stage of an entropy decoder and a larger backing store of context models. Each cache line keeps one complete group of adjacent models, so a single residency check covers every model that the next few bins may need. The decode pipeline reads one model and writes back one updated model per cycle. A read that misses holds the pipeline for a fixed two cycles. During that time the least recently used line is written back to the backing store and then refilled with the requested group.

A prefetch unit next to the pipeline can do two things. It can ask for a group to be loaded ahead of time, and it can mark a group that is already resident as most recently used, which keeps that group from becoming the next victim. The backing store is a behavioural model inside the block. Its contents come from a fixed seed formula at reset, so the surrounding logic and the bench both know every initial model value.

Top module: `ctx_set_cache`

## Requirements
- R1: A context index of `CTX_IDX_W` bits splits into a group number (its upper bits) and an offset within the group (its low 2 bits when `MODELS_PER_SET` is 4, its low 3 bits when it is 8). When the group is resident and no fill is in progress, a read returns the `MODEL_W`-bit model at that offset in the same cycle, with `rd_stall` low.
- R2: After reset every line is invalid, so the first read of any group misses. The backing store holds model i = (37*i + 11) mod 2^`MODEL_W` for every index i.
- R3: A read that misses raises `rd_stall` in the cycle it is presented and in the following cycle (the fill cycle). The same request presented in the cycle after that is served from the cache without a stall. `rd_stall` is low whenever there is no read and no fill in progress.
- R4: When a line is needed and some line is invalid, the lowest-numbered invalid line is filled, and no resident group is evicted.
- R5: When every line is valid, the victim is the least recently used line. A read hit makes its line most recently used in the same cycle, and a freshly filled line also becomes most recently used.
- R6: Before a valid victim line is replaced, all of its models, including updates written while it was resident, are written back to the backing store. A later miss on that group returns the updated values.
- R7: A write updates the model in the resident line that holds its group. If the group is not resident, the write goes straight to the backing store. A write presented during a fill cycle is not accepted and changes nothing.
- R8: A refresh request for a resident group makes that line most recently used without moving any data. A refresh for a group that is not resident has no effect.
- R9: A prefetch fill loads a group that is not resident, without stalling, but only when no fill is in progress and there is neither a read nor a write in that cycle. In every other case it is dropped, including when a demand miss in the same cycle already starts a fill, so at most one fill takes place and no group is ever held in two lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Demand read of one model; hold it while `rd_stall` is high |
| rd_idx | input | CTX_IDX_W | Context index of the demand read |
| rd_data | output | MODEL_W | Model returned on a hit |
| rd_stall | output | 1 | Pipeline hold while a miss is being serviced |
| wr_en | input | 1 | Write of an updated model |
| wr_idx | input | CTX_IDX_W | Context index of the write |
| wr_data | input | MODEL_W | Updated model value |
| pf_fill | input | 1 | Prefetch request to load a group |
| pf_fill_set | input | CTX_IDX_W-log2(MODELS_PER_SET) | Group number to load |
| pf_touch | input | 1 | Request to mark a group as most recently used |
| pf_touch_set | input | CTX_IDX_W-log2(MODELS_PER_SET) | Group number to refresh |

## Verification
The bench forces evictions in several specific orders so that recency has to be tracked exactly. A design that ignored hit-time updates, refreshes or invalid-first allocation would evict a group the bench still expects to be resident, and that would show up as an unexpected stall. It writes updated models to lines that are later evicted and then reads them back: a lost write-back returns the seed value instead of the update. It also places writes inside fill cycles, and places prefetches next to demand misses, reads, writes and groups that are already resident. A design that accepted those requests would return altered data or produce a missing stall. A long run of random mixed traffic then compares stall and data on every cycle against the bench's behavioural model.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;

   typedef enum logic [0:0] {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;

   // Reset content of the backing store; callers truncate to the model width.
   function automatic int ctx_seed(input int idx);
      return idx * 37 + 11;
   endfunction

endpackage

// File: rtl/ctx_tag_match.sv
module ctx_tag_match #(
   parameter int N_LINES = 2,
   parameter int SET_W   = 4,
   parameter int LINE_W  = 1
) (
   input  logic [N_LINES-1:0]            valid,
   input  logic [N_LINES-1:0][SET_W-1:0] tags,
   input  logic [SET_W-1:0]              query,
   output logic                          hit,
   output logic [LINE_W-1:0]             line
);

   always_comb begin
      hit  = 1'b0;
      line = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (!hit && valid[i] && (tags[i] == query)) begin
            hit  = 1'b1;
            line = LINE_W'(i);
         end
      end
   end

endmodule

// File: rtl/ctx_lru_ages.sv
module ctx_lru_ages #(
   parameter int N_LINES = 2,
   parameter int LINE_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_en,
   input  logic [LINE_W-1:0] first_line,
   input  logic              second_en,
   input  logic [LINE_W-1:0] second_line,
   output logic [LINE_W-1:0] lru_line
);

   generate
      if (N_LINES == 1) begin : g_single
         assign lru_line = '0;
      end else begin : g_multi
         // age 0 is most recent, N_LINES-1 is the next victim
         logic [N_LINES-1:0][LINE_W-1:0] age_q, age_mid, age_d;

         always_comb begin
            age_mid = age_q;
            if (first_en) begin
               for (int i = 0; i < N_LINES; i++) begin
                  if (LINE_W'(i) == first_line)
                     age_mid[i] = '0;
                  else if (age_q[i] < age_q[first_line])
                     age_mid[i] = age_q[i] + LINE_W'(1);
               end
            end
            age_d = age_mid;
            if (second_en) begin
               for (int i = 0; i < N_LINES; i++) begin
                  if (LINE_W'(i) == second_line)
                     age_d[i] = '0;
                  else if (age_mid[i] < age_mid[second_line])
                     age_d[i] = age_mid[i] + LINE_W'(1);
               end
            end
         end

         always_comb begin
            lru_line = '0;
            for (int i = 0; i < N_LINES; i++) begin
               if (age_q[i] == LINE_W'(N_LINES - 1))
                  lru_line = LINE_W'(i);
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_LINES; i++)
                  age_q[i] <= LINE_W'(i);
            end else begin
               age_q <= age_d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctx_backing_mem.sv
module ctx_backing_mem
   import ctx_cache_pkg::*;
#(
   parameter int MODELS_PER_SET = 8,
   parameter int MODEL_W        = 7,
   parameter int SET_W          = 4,
   parameter int OFF_W          = 3
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [SET_W-1:0]                        rd_set,
   output logic [MODELS_PER_SET-1:0][MODEL_W-1:0]  rd_line,
   input  logic                                    set_we,
   input  logic [SET_W-1:0]                        set_addr,
   input  logic [MODELS_PER_SET-1:0][MODEL_W-1:0]  set_data,
   input  logic                                    model_we,
   input  logic [SET_W+OFF_W-1:0]                  model_idx,
   input  logic [MODEL_W-1:0]                      model_data
);

   localparam int N_MODELS = (1 << (SET_W + OFF_W));

   logic [MODEL_W-1:0] store [N_MODELS];

   always_comb begin
      for (int k = 0; k < MODELS_PER_SET; k++)
         rd_line[k] = store[{rd_set, OFF_W'(k)}];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_MODELS; i++)
            store[i] <= MODEL_W'(ctx_seed(i));
      end else begin
         if (set_we) begin
            for (int k = 0; k < MODELS_PER_SET; k++)
               store[{set_addr, OFF_W'(k)}] <= set_data[k];
         end else if (model_we) begin
            store[model_idx] <= model_data;
         end
      end
   end

endmodule

// File: rtl/ctx_set_cache.sv
module ctx_set_cache
   import ctx_cache_pkg::*;
#(
   parameter int NUM_LINES      = 2,
   parameter int MODELS_PER_SET = 8,
   parameter int MODEL_W        = 7,
   parameter int CTX_IDX_W      = 7
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          rd_req,
   input  logic [CTX_IDX_W-1:0]                          rd_idx,
   output logic [MODEL_W-1:0]                            rd_data,
   output logic                                          rd_stall,
   input  logic                                          wr_en,
   input  logic [CTX_IDX_W-1:0]                          wr_idx,
   input  logic [MODEL_W-1:0]                            wr_data,
   input  logic                                          pf_fill,
   input  logic [CTX_IDX_W-$clog2(MODELS_PER_SET)-1:0]   pf_fill_set,
   input  logic                                          pf_touch,
   input  logic [CTX_IDX_W-$clog2(MODELS_PER_SET)-1:0]   pf_touch_set
);

   localparam int OFF_W  = $clog2(MODELS_PER_SET);
   localparam int SET_W  = CTX_IDX_W - OFF_W;
   localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int N_QRY  = 3;   // 0: demand read, 1: write, 2: refresh

   generate
      if (MODELS_PER_SET != 4 && MODELS_PER_SET != 8) begin : g_bad_group
         $error("MODELS_PER_SET must be 4 or 8");
      end
      if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
         $error("NUM_LINES must lie in 1..64");
      end
      if (MODEL_W < 1) begin : g_bad_width
         $error("MODEL_W must be positive");
      end
      if (SET_W < 1 || (1 << SET_W) < NUM_LINES) begin : g_bad_index
         $error("CTX_IDX_W too small for the group count");
      end
   endgenerate

   // line storage
   logic [NUM_LINES-1:0]                                  valid_q;
   logic [NUM_LINES-1:0][SET_W-1:0]                       tag_q;
   logic [NUM_LINES-1:0][MODELS_PER_SET-1:0][MODEL_W-1:0] data_q;

   fill_state_e        state_q;
   logic [SET_W-1:0]   fill_set_q;
   logic [LINE_W-1:0]  fill_line_q;

   // index split
   logic [SET_W-1:0] rd_set, wr_set;
   logic [OFF_W-1:0] rd_off, wr_off;
   assign rd_set = rd_idx[CTX_IDX_W-1:OFF_W];
   assign rd_off = rd_idx[OFF_W-1:0];
   assign wr_set = wr_idx[CTX_IDX_W-1:OFF_W];
   assign wr_off = wr_idx[OFF_W-1:0];

   // parallel tag lookups
   logic [N_QRY-1:0][SET_W-1:0]  qry;
   logic [N_QRY-1:0]             qry_hit;
   logic [N_QRY-1:0][LINE_W-1:0] qry_line;
   assign qry[0] = rd_set;
   assign qry[1] = wr_set;
   assign qry[2] = pf_touch_set;

   generate
      for (genvar k = 0; k < N_QRY; k++) begin : g_lookup
         ctx_tag_match #(
            .N_LINES (NUM_LINES),
            .SET_W   (SET_W),
            .LINE_W  (LINE_W)
         ) u_match (
            .valid (valid_q),
            .tags  (tag_q),
            .query (qry[k]),
            .hit   (qry_hit[k]),
            .line  (qry_line[k])
         );
      end
   endgenerate

   logic pf_resident;
   always_comb begin
      pf_resident = 1'b0;
      for (int i = 0; i < NUM_LINES; i++)
         if (valid_q[i] && tag_q[i] == pf_fill_set)
            pf_resident = 1'b1;
   end

   // victim choice: lowest invalid line first, otherwise the oldest
   logic [LINE_W-1:0] lru_line, victim_line;
   logic              free_found;
   always_comb begin
      victim_line = lru_line;
      free_found  = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (!free_found && !valid_q[i]) begin
            victim_line = LINE_W'(i);
            free_found  = 1'b1;
         end
      end
   end

   // control
   logic fill_active, demand_hit, demand_miss, wr_take, pf_take, install_en;
   logic [LINE_W-1:0] install_line;
   logic [SET_W-1:0]  install_set;

   assign fill_active  = (state_q == FS_FILL);
   assign demand_hit   = !fill_active && rd_req && qry_hit[0];
   assign demand_miss  = !fill_active && rd_req && !qry_hit[0];
   assign rd_stall     = demand_miss || fill_active;
   assign rd_data      = qry_hit[0] ? data_q[qry_line[0]][rd_off] : '0;
   assign wr_take      = wr_en && !fill_active;
   assign pf_take      = pf_fill && !fill_active && !rd_req && !wr_en && !pf_resident;
   assign install_en   = fill_active || pf_take;
   assign install_line = fill_active ? fill_line_q : victim_line;
   assign install_set  = fill_active ? fill_set_q  : pf_fill_set;

   // backing store
   logic [MODELS_PER_SET-1:0][MODEL_W-1:0] mem_line;

   ctx_backing_mem #(
      .MODELS_PER_SET (MODELS_PER_SET),
      .MODEL_W        (MODEL_W),
      .SET_W          (SET_W),
      .OFF_W          (OFF_W)
   ) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set     (install_set),
      .rd_line    (mem_line),
      .set_we     (install_en && valid_q[install_line]),
      .set_addr   (tag_q[install_line]),
      .set_data   (data_q[install_line]),
      .model_we   (wr_take && !qry_hit[1]),
      .model_idx  (wr_idx),
      .model_data (wr_data)
   );

   // recency: refresh applies first, then the hit or the fill
   ctx_lru_ages #(
      .N_LINES (NUM_LINES),
      .LINE_W  (LINE_W)
   ) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .first_en    (pf_touch && qry_hit[2]),
      .first_line  (qry_line[2]),
      .second_en   (demand_hit || install_en),
      .second_line (demand_hit ? qry_line[0] : install_line),
      .lru_line    (lru_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q     <= '0;
         tag_q       <= '0;
         data_q      <= '0;
         state_q     <= FS_IDLE;
         fill_set_q  <= '0;
         fill_line_q <= '0;
      end else begin
         if (wr_take && qry_hit[1])
            data_q[qry_line[1]][wr_off] <= wr_data;
         if (install_en) begin
            data_q[install_line]  <= mem_line;
            tag_q[install_line]   <= install_set;
            valid_q[install_line] <= 1'b1;
         end
         case (state_q)
            FS_IDLE: begin
               if (demand_miss) begin
                  state_q     <= FS_FILL;
                  fill_set_q  <= rd_set;
                  fill_line_q <= victim_line;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ctx_set_cache_chk.sv
module ctx_set_cache_chk #(
   parameter int NUM_LINES = 2,
   parameter int SET_W     = 4,
   parameter int LINE_W    = 1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            fill_active,
   input logic                            demand_miss,
   input logic                            install_en,
   input logic [LINE_W-1:0]               install_line,
   input logic [NUM_LINES-1:0]            valid_q,
   input logic [NUM_LINES-1:0][SET_W-1:0] tag_q
);

   assert_miss_enters_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      demand_miss |=> fill_active);

   assert_fill_lasts_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_active |=> !fill_active);

   assert_filled_line_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      install_en |=> valid_q[$past(install_line)]);

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         assert_line_stays_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[i] |=> valid_q[i]);
         for (genvar j = i + 1; j < NUM_LINES; j++) begin : g_pair
            assert_no_duplicate_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_q[i] && valid_q[j]) |-> (tag_q[i] != tag_q[j]));
         end
      end
   endgenerate

endmodule

bind ctx_set_cache ctx_set_cache_chk #(
   .NUM_LINES (NUM_LINES),
   .SET_W     (SET_W),
   .LINE_W    (LINE_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fill_active  (fill_active),
   .demand_miss  (demand_miss),
   .install_en   (install_en),
   .install_line (install_line),
   .valid_q      (valid_q),
   .tag_q        (tag_q)
);

// File: tb/test_ctx_set_cache.sv
`timescale 1ns/1ps
module test_ctx_set_cache;

   localparam int NL  = 2;
   localparam int MPS = 8;
   localparam int MW  = 7;
   localparam int IW  = 7;
   localparam int OW  = 3;
   localparam int SW  = IW - OW;
   localparam int NM  = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic [IW-1:0] rd_idx = '0;
   logic [MW-1:0] rd_data;
   logic          rd_stall;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [MW-1:0] wr_data = '0;
   logic          pf_fill = 1'b0;
   logic [SW-1:0] pf_fill_set = '0;
   logic          pf_touch = 1'b0;
   logic [SW-1:0] pf_touch_set = '0;

   always #10 clk = ~clk;

   ctx_set_cache #(
      .NUM_LINES (NL), .MODELS_PER_SET (MPS), .MODEL_W (MW), .CTX_IDX_W (IW)
   ) i_ctx_set_cache (
      .clk (clk), .rst_n (rst_n),
      .rd_req (rd_req), .rd_idx (rd_idx), .rd_data (rd_data), .rd_stall (rd_stall),
      .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
      .pf_fill (pf_fill), .pf_fill_set (pf_fill_set),
      .pf_touch (pf_touch), .pf_touch_set (pf_touch_set)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R2";
   bit    last_stall;
   bit    done = 1'b0;

   // behavioural reference state
   int mem [NM];
   int lset [NL];
   bit lval [NL];
   int ldat [NL][MPS];
   int order [$];
   bit mfill;
   int mfset, mfline;

   function automatic int find(input int s);
      for (int i = 0; i < NL; i++)
         if (lval[i] && lset[i] == s) return i;
      return -1;
   endfunction

   function automatic int pick_victim();
      for (int i = 0; i < NL; i++)
         if (!lval[i]) return i;
      return order[$];
   endfunction

   task automatic touch(input int l);
      for (int i = 0; i < order.size(); i++)
         if (order[i] == l) begin order.delete(i); break; end
      order.push_front(l);
   endtask

   task automatic install(input int l, input int s);
      if (lval[l])
         for (int k = 0; k < MPS; k++) mem[lset[l]*MPS + k] = ldat[l][k];
      for (int k = 0; k < MPS; k++) ldat[l][k] = mem[s*MPS + k];
      lset[l] = s;
      lval[l] = 1'b1;
      touch(l);
   endtask

   task automatic model_reset();
      for (int i = 0; i < NM; i++) mem[i] = (37*i + 11) % (1 << MW);
      for (int i = 0; i < NL; i++) lval[i] = 1'b0;
      order.delete();
      for (int i = 0; i < NL; i++) order.push_back(i);
      mfill = 1'b0;
   endtask

   task automatic step(input bit r, input int ri, input bit w, input int wi, input int wd,
                       input bit p, input int ps, input bit t, input int ts);
      int h, rs, ro, vic;
      bit es, nfill;
      @(negedge clk);
      rd_req = r; rd_idx = IW'(ri);
      wr_en = w; wr_idx = IW'(wi); wr_data = MW'(wd);
      pf_fill = p; pf_fill_set = SW'(ps);
      pf_touch = t; pf_touch_set = SW'(ts);
      #1;
      rs = ri / MPS; ro = ri % MPS;
      h = find(rs);
      es = mfill || (r && h < 0);
      n_cmp++;
      if (rd_stall !== es) begin
         n_bad++;
         $display("FAIL %s rd_stall idx %0d actual %0b expected %0b", cur_req, ri, rd_stall, es);
      end
      if (r && !es) begin
         n_cmp++;
         if (rd_data !== MW'(ldat[h][ro])) begin
            n_bad++;
            $display("FAIL %s rd_data idx %0d actual %0d expected %0d",
                     cur_req, ri, rd_data, ldat[h][ro]);
         end
      end
      last_stall = es;
      // state advance for the coming edge
      vic = pick_victim();
      nfill = !mfill && r && h < 0;
      if (!mfill && w) begin
         int wh;
         wh = find(wi / MPS);
         if (wh >= 0) ldat[wh][wi % MPS] = wd; else mem[wi] = wd;
      end
      if (t && find(ts) >= 0) touch(find(ts));
      if (!mfill && r && h >= 0) touch(h);
      if (mfill) begin
         install(mfline, mfset);
         mfill = 1'b0;
      end else if (p && !r && !w && find(ps) < 0) begin
         install(vic, ps);
      end
      if (nfill) begin
         mfill = 1'b1; mfset = rs; mfline = vic;
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(input int idx);
      step(1, idx, 0, 0, 0, 0, 0, 0, 0);
      for (int n = 0; n < 4 && last_stall; n++)
         step(1, idx, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(input int idx, input int val);
      step(0, 0, 1, idx, val, 0, 0, 0, 0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R2";            // reset: no stall, cold miss, seed data
      idle();
      rd(5);
      cur_req = "R1";            // group 1 offsets, hits without stall
      rd(13); rd(9); rd(15);
      cur_req = "R4";            // second group took the free line
      rd(2);
      cur_req = "R5";            // recency-driven evictions
      rd(20); rd(3); rd(9); rd(22); rd(4);
      cur_req = "R6";            // write-back of updated models
      rd(17); wr(17, 'h55); wr(23, 'h01);
      rd(40); rd(48); rd(17); rd(23);
      cur_req = "R7";            // write-through and write during fill
      wr(100, 'h11); rd(100);
      step(1, 60, 0, 0, 0, 0, 0, 0, 0);
      step(1, 60, 1, 100, 'h7f, 0, 0, 0, 0);
      rd(60); rd(100);
      cur_req = "R8";            // refresh keeps the older group
      step(0, 0, 0, 0, 0, 0, 0, 1, 12);
      rd(8); rd(100);
      step(0, 0, 0, 0, 0, 0, 0, 1, 3);
      rd(24); rd(8);
      cur_req = "R9";            // prefetch accepted and dropped cases
      step(0, 0, 0, 0, 0, 1, 9, 0, 0);
      rd(72);
      step(1, 88, 0, 0, 0, 1, 13, 0, 0);
      rd(88); rd(104);
      step(1, 120, 0, 0, 0, 1, 15, 0, 0);
      rd(120); rd(121);
      step(0, 0, 1, 1, 3, 1, 4, 0, 0);
      rd(32);
      step(0, 0, 0, 0, 0, 1, 4, 0, 0);
      rd(33);
      cur_req = "R3";            // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         step($urandom_range(0, 2) != 0, $urandom_range(0, NM-1),
              $urandom_range(0, 3) == 0, $urandom_range(0, NM-1), $urandom_range(0, 127),
              $urandom_range(0, 3) == 0, $urandom_range(0, (1<<SW)-1),
              $urandom_range(0, 3) == 0, $urandom_range(0, (1<<SW)-1));
      end
      idle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule